// File: doc/BRIEF.md
# Fixed-Point to Integer Output Converter

This block is the last arithmetic stage after a filter. It takes a signed fixed-point result, with a fraction width set by a parameter, and turns it into an integer output sample. The output width and signedness are also parameters. Four stages run in a fixed order: a shift of the binary point, removal of the fraction bits by a selectable rounding rule, a fix-up of negative values for unsigned outputs, and a clamp to a range. Each stage is one register deep.

Each input word comes with a valid flag and with its own configuration: a shift amount, a rounding rule, a choice of how negative values are handled, and optional lower and upper guard limits. The configuration is captured in the same clock edge as the word. It then moves down the pipeline with that word, so back-to-back words may use different settings.

Top module: `fxo_out_convert`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly four clock edges later, counting the edge that samples the input as the first. After reset `out_valid` and `out_data` are 0.
- R2: `cfg_shift` is a two's-complement amount. It multiplies the input by 2 to that power, which moves the binary point right by that many places. Values below -16 act as -16 and values above +16 act as +16. The shift is exact: no bit is lost before rounding.
- R3: With `cfg_round` = 0 (or 3), the fraction bits are dropped. This rounds toward negative infinity, for negative values as well.
- R4: With `cfg_round` = 1, the value goes to the nearest integer. An exact half goes toward positive infinity.
- R5: With `cfg_round` = 2, the value goes to the nearest integer. An exact half goes to the even neighbour.
- R6: For an unsigned output with `cfg_neg_abs` = 0, a negative rounded value becomes the lower limit of the range.
- R7: For an unsigned output with `cfg_neg_abs` = 1, a negative rounded value is replaced by its magnitude before the clamp.
- R8: With `cfg_guard_en` = 0, results outside the range the output width allows (0 to 2^OUT_W-1 when unsigned) saturate to its nearer end.
- R9: With `cfg_guard_en` = 1, results saturate to [`cfg_guard_min`, `cfg_guard_max`]. The limits are read with the output's signedness. If min exceeds max, the result is min.
- R10: Every configuration input is sampled with its own word. A change on the next cycle does not affect a word that is already in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | IN_W | Signed fixed-point input, FRAC_W fraction bits |
| cfg_shift | input | 6 | Signed binary-point shift, -16..+16 |
| cfg_round | input | 2 | 0 truncate, 1 half up, 2 half even, 3 truncate |
| cfg_neg_abs | input | 1 | Unsigned output: 1 magnitude, 0 clamp to minimum |
| cfg_guard_en | input | 1 | Use guard limits instead of the full output range |
| cfg_guard_min | input | OUT_W | Lower guard limit |
| cfg_guard_max | input | OUT_W | Upper guard limit |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | OUT_W | Integer output sample |

## Verification
A word and its configuration are driven just after a falling edge and captured at the next rising edge. Its result is visible after the third rising edge that follows. The bench holds the expected value and valid flag in a four-entry ring. At each falling edge it compares the outputs with the entry written four falling edges earlier, and only then overwrites that entry with the new stimulus. This catches any extra or missing stage as well as wrong values. A run of words with alternating configurations shows that each setting stays with its own word.

// File: rtl/fxo_pkg.sv
package fxo_pkg;
  typedef enum logic [1:0] {
    RND_TRUNC     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_EVEN = 2'd2,
    RND_TRUNC_ALT = 2'd3
  } rnd_mode_e;

  localparam int SHIFT_MAX = 16;
endpackage

// File: rtl/fxo_scale.sv
module fxo_scale #(
  parameter int IN_W = 24,
  localparam int SH_W = IN_W + 2 * fxo_pkg::SHIFT_MAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [IN_W-1:0]        in_data,
  input  logic signed [5:0]      shift,
  output logic                   sc_valid,
  output logic signed [SH_W-1:0] sc_data
);
  // Map -16..+16 onto a left shift of 0..32 of a pre-widened word.
  function automatic logic [5:0] shift_amt(input logic signed [5:0] s);
    if (s < -6'sd16)      return 6'd0;
    else if (s > 6'sd16)  return 6'd32;
    else                  return 6'(s) + 6'd16;
  endfunction

  logic signed [SH_W-1:0] widened;
  assign widened = SH_W'($signed(in_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_valid <= 1'b0;
      sc_data  <= '0;
    end else begin
      sc_valid <= in_valid;
      sc_data  <= widened <<< shift_amt(shift);
    end
  end
endmodule

// File: rtl/fxo_round.sv
module fxo_round #(
  parameter int SH_W = 56,
  parameter int FB   = 24,
  parameter int IW   = 34
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [SH_W-1:0] in_data,
  input  fxo_pkg::rnd_mode_e     mode,
  output logic                   round_tie,
  output logic                   round_inc,
  output logic                   rn_valid,
  output logic signed [IW-1:0]   rn_data
);
  import fxo_pkg::*;

  logic signed [IW-1:0] floor_v;
  logic                 half_bit;
  logic                 sticky;

  assign floor_v  = IW'($signed(in_data[SH_W-1:FB]));
  assign half_bit = in_data[FB-1];
  assign sticky   = |in_data[FB-2:0];
  assign round_tie = half_bit && !sticky;

  function automatic logic inc_fn(input rnd_mode_e m, input logic h,
                                  input logic st, input logic lsb);
    case (m)
      RND_HALF_UP:   return h;
      RND_HALF_EVEN: return h && (st || lsb);
      default:       return 1'b0;
    endcase
  endfunction

  assign round_inc = inc_fn(mode, half_bit, sticky, floor_v[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rn_valid <= 1'b0;
      rn_data  <= '0;
    end else begin
      rn_valid <= in_valid;
      rn_data  <= floor_v + IW'(round_inc);
    end
  end
endmodule

// File: rtl/fxo_sign.sv
module fxo_sign #(
  parameter int IW         = 34,
  parameter bit OUT_SIGNED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  input  logic                 neg_abs,
  output logic                 sg_valid,
  output logic signed [IW-1:0] sg_data
);
  function automatic logic signed [IW-1:0] fix_fn(input logic signed [IW-1:0] v,
                                                  input logic a);
    if (OUT_SIGNED || !v[IW-1]) return v;
    else if (a)                 return -v;
    else                        return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_valid <= 1'b0;
      sg_data  <= '0;
    end else begin
      sg_valid <= in_valid;
      sg_data  <= fix_fn(in_data, neg_abs);
    end
  end
endmodule

// File: rtl/fxo_clamp.sv
module fxo_clamp #(
  parameter int IW         = 34,
  parameter int OUT_W      = 10,
  parameter bit OUT_SIGNED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  input  logic                 guard_en,
  input  logic [OUT_W-1:0]     guard_min,
  input  logic [OUT_W-1:0]     guard_max,
  output logic signed [IW-1:0] lim_lo,
  output logic signed [IW-1:0] lim_hi,
  output logic                 cl_valid,
  output logic [OUT_W-1:0]     cl_data
);
  logic signed [IW-1:0] full_lo, full_hi, g_lo, g_hi;

  generate
    if (OUT_SIGNED) begin : g_signed
      assign full_lo = -(IW'(1) <<< (OUT_W - 1));
      assign full_hi = (IW'(1) <<< (OUT_W - 1)) - IW'(1);
      assign g_lo    = IW'($signed(guard_min));
      assign g_hi    = IW'($signed(guard_max));
    end else begin : g_unsigned
      assign full_lo = '0;
      assign full_hi = (IW'(1) <<< OUT_W) - IW'(1);
      assign g_lo    = IW'(guard_min);
      assign g_hi    = IW'(guard_max);
    end
  endgenerate

  assign lim_lo = guard_en ? g_lo : full_lo;
  assign lim_hi = guard_en ? g_hi : full_hi;

  // Upper bound first, lower bound last: an inverted pair yields the minimum.
  function automatic logic signed [IW-1:0] sat_fn(input logic signed [IW-1:0] v,
                                                  input logic signed [IW-1:0] lo,
                                                  input logic signed [IW-1:0] hi);
    logic signed [IW-1:0] t;
    t = (v > hi) ? hi : v;
    return (t < lo) ? lo : t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_valid <= 1'b0;
      cl_data  <= '0;
    end else begin
      cl_valid <= in_valid;
      cl_data  <= OUT_W'(sat_fn(in_data, lim_lo, lim_hi));
    end
  end
endmodule

// File: rtl/fxo_out_convert.sv
module fxo_out_convert #(
  parameter int IN_W       = 24,
  parameter int FRAC_W     = 8,
  parameter int OUT_W      = 10,
  parameter bit OUT_SIGNED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic [5:0]        cfg_shift,
  input  logic [1:0]        cfg_round,
  input  logic              cfg_neg_abs,
  input  logic              cfg_guard_en,
  input  logic [OUT_W-1:0]  cfg_guard_min,
  input  logic [OUT_W-1:0]  cfg_guard_max,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  import fxo_pkg::*;

  localparam int SH_W = IN_W + 2 * SHIFT_MAX;
  localparam int FB   = FRAC_W + SHIFT_MAX;
  localparam int IW   = SH_W - FB + 2;

  // Configuration travelling with each word
  rnd_mode_e          mode_q1;
  logic               abs_q1, abs_q2;
  logic               gen_q1, gen_q2, gen_q3;
  logic [OUT_W-1:0]   gmin_q1, gmin_q2, gmin_q3;
  logic [OUT_W-1:0]   gmax_q1, gmax_q2, gmax_q3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q1 <= RND_TRUNC;
      {abs_q1, abs_q2} <= '0;
      {gen_q1, gen_q2, gen_q3} <= '0;
      {gmin_q1, gmin_q2, gmin_q3} <= '0;
      {gmax_q1, gmax_q2, gmax_q3} <= '0;
    end else begin
      mode_q1 <= rnd_mode_e'(cfg_round);
      abs_q1  <= cfg_neg_abs;   abs_q2  <= abs_q1;
      gen_q1  <= cfg_guard_en;  gen_q2  <= gen_q1;  gen_q3  <= gen_q2;
      gmin_q1 <= cfg_guard_min; gmin_q2 <= gmin_q1; gmin_q3 <= gmin_q2;
      gmax_q1 <= cfg_guard_max; gmax_q2 <= gmax_q1; gmax_q3 <= gmax_q2;
    end
  end

  // Named inter-stage wires
  logic                   sc_valid, rn_valid, sg_valid;
  logic signed [SH_W-1:0] sc_data;
  logic signed [IW-1:0]   rn_data, sg_data, lim_lo, lim_hi;
  logic                   round_tie, round_inc;

  fxo_scale #(.IN_W(IN_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .shift(cfg_shift), .sc_valid(sc_valid), .sc_data(sc_data));

  fxo_round #(.SH_W(SH_W), .FB(FB), .IW(IW)) u_round (
    .clk(clk), .rst_n(rst_n), .in_valid(sc_valid), .in_data(sc_data),
    .mode(mode_q1), .round_tie(round_tie), .round_inc(round_inc),
    .rn_valid(rn_valid), .rn_data(rn_data));

  fxo_sign #(.IW(IW), .OUT_SIGNED(OUT_SIGNED)) u_sign (
    .clk(clk), .rst_n(rst_n), .in_valid(rn_valid), .in_data(rn_data),
    .neg_abs(abs_q2), .sg_valid(sg_valid), .sg_data(sg_data));

  fxo_clamp #(.IW(IW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED)) u_clamp (
    .clk(clk), .rst_n(rst_n), .in_valid(sg_valid), .in_data(sg_data),
    .guard_en(gen_q3), .guard_min(gmin_q3), .guard_max(gmax_q3),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .cl_valid(out_valid), .cl_data(out_data));
endmodule

// File: rtl/fxo_out_convert_chk.sv
module fxo_out_convert_chk #(
  parameter int IW         = 34,
  parameter int OUT_W      = 10,
  parameter bit OUT_SIGNED = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [OUT_W-1:0]     out_data,
  input logic [1:0]           mode_q1,
  input logic                 sc_valid,
  input logic                 round_tie,
  input logic                 round_inc,
  input logic signed [IW-1:0] rn_data,
  input logic                 sg_valid,
  input logic signed [IW-1:0] sg_data,
  input logic signed [IW-1:0] lim_lo,
  input logic signed [IW-1:0] lim_hi
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  logic signed [IW-1:0] out_ext;
  always_comb begin
    if (OUT_SIGNED) out_ext = IW'($signed(out_data));
    else            out_ext = IW'(out_data);
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_trunc_no_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && (mode_q1 == 2'd0 || mode_q1 == 2'd3)) |-> !round_inc);

  p_tie_goes_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && mode_q1 == 2'd1 && round_tie) |-> round_inc);

  p_tie_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && mode_q1 == 2'd2 && round_tie) |=> !rn_data[0]);

  p_unsigned_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_valid && !OUT_SIGNED) |-> !sg_data[IW-1]);

  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_valid && lim_lo <= lim_hi) |=> (out_ext >= $past(lim_lo) && out_ext <= $past(lim_hi)));
endmodule

bind fxo_out_convert fxo_out_convert_chk #(
  .IW(IW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .mode_q1(mode_q1), .sc_valid(sc_valid),
  .round_tie(round_tie), .round_inc(round_inc), .rn_data(rn_data),
  .sg_valid(sg_valid), .sg_data(sg_data), .lim_lo(lim_lo), .lim_hi(lim_hi));

// File: tb/tb_fxo_out_convert.sv
module tb_fxo_out_convert;
  localparam int IN_W = 24, FRAC_W = 8, OUT_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [5:0] cfg_shift = '0;
  logic [1:0] cfg_round = '0;
  logic cfg_neg_abs = 1'b0, cfg_guard_en = 1'b0;
  logic [OUT_W-1:0] cfg_guard_min = '0, cfg_guard_max = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;

  always #10 clk = ~clk;

  fxo_out_convert #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .OUT_SIGNED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_shift(cfg_shift), .cfg_round(cfg_round), .cfg_neg_abs(cfg_neg_abs),
    .cfg_guard_en(cfg_guard_en), .cfg_guard_min(cfg_guard_min),
    .cfg_guard_max(cfg_guard_max), .out_valid(out_valid), .out_data(out_data));

  int n_run = 0, n_fail = 0;
  bit exp_v[4];
  int exp_d[4];
  string exp_t[4];
  int slot = 0;
  bit done = 1'b0;

  // Reference: value * 2^s, integer division by powers of two, then fix-ups.
  function automatic longint model(input longint x, input int s_raw, input int mode,
                                   input bit nabs, input bit gen, input int gmin,
                                   input int gmax, output string tag);
    int s, e;
    longint q, r, h, lo, hi;
    s = (s_raw < -16) ? -16 : (s_raw > 16) ? 16 : s_raw;
    e = FRAC_W - s;
    tag = (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R3";
    if (s != s_raw) tag = "R2";
    if (e <= 0) q = x * (longint'(1) << (-e));
    else begin
      q = x >>> e;
      r = x - q * (longint'(1) << e);
      h = longint'(1) << (e - 1);
      if (mode == 1 && r >= h) q = q + 1;
      if (mode == 2 && (r > h || (r == h && q[0]))) q = q + 1;
    end
    if (q < 0) begin
      tag = nabs ? "R7" : "R6";
      q = nabs ? -q : 0;
    end
    lo = gen ? gmin : 0;
    hi = gen ? gmax : (1 << OUT_W) - 1;
    if (q > hi || q < lo) tag = gen ? "R9" : "R8";
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return q;
  endfunction

  task automatic check_slot();
    n_run++;
    if (out_valid !== exp_v[slot] || (exp_v[slot] && int'(out_data) != exp_d[slot])) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               exp_v[slot] ? exp_t[slot] : "R1", out_valid, out_data,
               exp_v[slot], exp_d[slot]);
    end
  endtask

  task automatic step(input bit v, input longint x, input int s, input int mode,
                      input bit nabs, input bit gen, input int gmin, input int gmax,
                      input string force_tag);
    string t;
    @(negedge clk);
    check_slot();
    in_valid = v; in_data = IN_W'(x); cfg_shift = 6'(s); cfg_round = 2'(mode);
    cfg_neg_abs = nabs; cfg_guard_en = gen;
    cfg_guard_min = OUT_W'(gmin); cfg_guard_max = OUT_W'(gmax);
    exp_v[slot] = v;
    exp_d[slot] = int'(model(x, s, mode, nabs, gen, gmin, gmax, t));
    exp_t[slot] = (force_tag != "") ? force_tag : t;
    slot = (slot + 1) % 4;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin exp_v[i] = 0; exp_d[i] = 0; exp_t[i] = "R1"; end
    repeat (3) @(negedge clk);
    n_run++;   // R1 reset state
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: valid=%0b data=%0d expected 0 0", out_valid, out_data);
    end
    rst_n = 1'b1;
    // Ties: 1.5, 2.5, -1.5 under each rule (R3 R4 R5 R6 R7)
    for (int m = 0; m < 3; m++) begin
      step(1, 'h180, 0, m, 0, 0, 0, 0, "");
      step(1, 'h280, 0, m, 0, 0, 0, 0, "");
      step(1, -'h180, 0, m, 1, 0, 0, 0, "");
      step(1, -'h180, 0, m, 0, 0, 0, 0, "");
    end
    step(1, 'h280, 0, 3, 0, 0, 0, 0, "R3");
    // Shift extremes and out-of-range amounts (R2)
    step(1, 3, 16, 0, 0, 0, 0, 0, "R2");
    step(1, 'h3FF00, -16, 1, 0, 0, 0, 0, "R2");
    step(1, 3, 25, 0, 0, 0, 0, 0, "R2");
    step(1, 'h7FFFFF, -30, 2, 0, 0, 0, 0, "R2");
    // Full-range saturation (R8) and guard limits (R9)
    step(1, 'h7FFFFF, 0, 0, 0, 0, 0, 0, "R8");
    step(1, -'h800000, 4, 0, 1, 0, 0, 0, "R8");
    step(1, 'h100, 0, 0, 0, 1, 64, 900, "R9");
    step(1, 'h7FFFFF, 0, 0, 0, 1, 64, 900, "R9");
    step(1, 'h10000, 0, 0, 0, 1, 700, 100, "R9");
    // Idle cycle then back-to-back different configs (R10, R1)
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 8; i++)
      step(1, 'h3A5 + i, (i % 2) ? 3 : -2, i % 3, i[0], i[1], 10 * i, 500 + i, "R10");
    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      int nb, s, gmin, gmax;
      longint x;
      nb = 1 + int'($urandom % 23);
      x = longint'($urandom % (32'd1 << nb));
      if ($urandom % 2) x = -x;
      s = ($urandom % 8 == 0) ? int'($urandom % 64) - 32 : int'($urandom % 33) - 16;
      gmin = int'($urandom % 512);
      gmax = gmin + int'($urandom % (1024 - gmin));
      step($urandom % 8 != 0, x, s, int'($urandom % 4), $urandom % 2,
           $urandom % 3 == 0, gmin, gmax, "");
    end
    repeat (5) step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule